// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder with a carry input and a carry output. The operands are cut into four slices of four bits each. Inside every slice, each bit position derives a propagate term (the XOR of its two operand bits) and a generate term (their AND). A lookahead network turns these terms into every carry of the slice as a flat sum of products, so no carry passes from one bit to the next inside a slice. The propagate term is used again to form the sum bit.

The slices are joined in one of two ways, chosen by a build parameter. In the rippled arrangement, the carry-out of each slice becomes the carry-in of the next. In the two-level arrangement, each slice also exports a slice propagate and a slice generate term. A second lookahead network, built like the one inside a slice, computes every slice carry-in from those terms and the adder carry-in. Both arrangements produce the same result. They differ only in how the slice carries are formed.

Top module: `cla_adder16`

## Requirements
- R1: For every bit, the propagate term is a XOR b and the generate term is a AND b. The two are never 1 together. As a result, a slice whose propagate is 1 never also has its generate at 1.
- R2: Sum bit i equals propagate(i) XOR carry(i), where carry(0) of the adder is `carry_in`.
- R3: Within a slice, every carry obeys c(i+1) = G(i) OR (P(i) AND c(i)). The logic forms each carry directly as a sum of products of the slice's P and G terms and its carry-in.
- R4: The slice propagate is the AND of the slice's four P terms. The slice generate is G3 + P3G2 + P3P2G1 + P3P2P1G0. When the slice propagate is 1, the slice carry-out equals the slice carry-in.
- R5: With the rippled join (JOIN = JOIN_RIPPLE), the carry into slice k+1 is the carry-out of slice k. `carry_out` is the carry-out of the last slice.
- R6: With the two-level join (JOIN = JOIN_LOOKAHEAD, the default), the slice carry-ins and `carry_out` come from a lookahead network over the slice P/G terms and `carry_in`. The results agree with what each slice's own carry-out gives.
- R7: For all inputs, {carry_out, sum_out} equals opa + opb + carry_in, taken as 17-bit unsigned values.
- R8: Two operands of all ones with carry_in 1 give sum_out 0xFFFF and carry_out 1.
- R9: Complementary alternating operands (0xAAAA with 0x5555) propagate in every bit. They give 0xFFFF with carry_out 0 when carry_in is 0, and 0x0000 with carry_out 1 when carry_in is 1.
- R10: Zero operands give sum_out equal to carry_in in bit 0 only, with carry_out 0.
- R11: Both join arrangements produce identical sum_out and carry_out for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The assertions check on every evaluation that each flattened slice carry matches the one-step recurrence, and that the slice propagate and generate terms never both assert. They also check that a slice carry-in always equals the previous slice's own carry-out, that the top-level lookahead carry-out matches its group terms, and that the full 17-bit result equals the arithmetic sum. Only the bench's scenarios can show that the two build variants agree with each other. The same holds for the named operand patterns: long propagate chains across every slice boundary, all ones with a carry, and zero with a carry. These patterns produce the expected values.

// File: rtl/cla_pkg.sv
package cla_pkg;

    typedef enum logic [0:0] {
        JOIN_RIPPLE    = 1'b0,
        JOIN_LOOKAHEAD = 1'b1
    } join_mode_e;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // one step of the carry recurrence, used by the checkers
    function automatic logic carry_step(input pg_t t, input logic c);
        return t.g | (t.p & c);
    endfunction

    function automatic pg_t make_pg(input logic a, input logic b);
        pg_t r;
        r.p = a ^ b;
        r.g = a & b;
        return r;
    endfunction

endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
    import cla_pkg::*;
(
    input  logic a,
    input  logic b,
    output pg_t  pg
);

    assign pg = make_pg(a, b);

    always_comb begin
        // R1
        pg_excl_chk: assert (!(pg.p && pg.g))
            else $error("propagate and generate both set");
    end

endmodule

// File: rtl/cla_la_net.sv
// Flat lookahead network: every carry is an OR of AND terms over P/G and c0.
module cla_la_net #(
    parameter int N = 4
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         c0,
    output logic [N:1]   carries,
    output logic         prop_all,
    output logic         gen_all
);

    always_comb begin
        logic term;
        logic orv;
        for (int i = 0; i < N; i++) begin
            term = c0;
            for (int j = 0; j <= i; j++) term = term & p[j];
            orv = term;
            for (int j = 0; j <= i; j++) begin
                term = g[j];
                for (int k = j + 1; k <= i; k++) term = term & p[k];
                orv = orv | term;
            end
            carries[i+1] = orv;
        end
    end

    always_comb begin
        logic term;
        logic orv;
        orv = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = g[j];
            for (int k = j + 1; k < N; k++) term = term & p[k];
            orv = orv | term;
        end
        gen_all  = orv;
        prop_all = &p;
    end

    always_comb begin
        // R4
        group_pg_chk: assert (carries[N] == (gen_all | (prop_all & c0)))
            else $error("group terms disagree with last carry");
    end

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          cout,
    output logic          gprop,
    output logic          ggen
);

    pg_t          pgv [GW];
    logic [GW-1:0] pv;
    logic [GW-1:0] gv;
    logic [GW:0]   cv;

    for (genvar i = 0; i < GW; i++) begin : g_bit
        cla_pg_cell u_cell (
            .a  (a[i]),
            .b  (b[i]),
            .pg (pgv[i])
        );
        assign pv[i] = pgv[i].p;
        assign gv[i] = pgv[i].g;
    end

    assign cv[0] = cin;

    cla_la_net #(.N(GW)) u_net (
        .p        (pv),
        .g        (gv),
        .c0       (cin),
        .carries  (cv[GW:1]),
        .prop_all (gprop),
        .gen_all  (ggen)
    );

    // R2
    assign sum  = pv ^ cv[GW-1:0];
    assign cout = cv[GW];

    for (genvar i = 0; i < GW; i++) begin : g_chk
        always_comb begin
            // R3
            carry_rec_chk: assert (cv[i+1] == carry_step(pgv[i], cv[i]))
                else $error("flat carry %0d breaks recurrence", i + 1);
        end
    end

    always_comb begin
        // R4
        group_pass_chk: assert (!gprop || (cout == cin))
            else $error("propagating group altered carry");
        // R1
        group_excl_chk: assert (!(gprop && ggen))
            else $error("group propagate and generate both set");
    end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int         WIDTH   = 16,
    parameter int         GROUP_W = 4,
    parameter join_mode_e JOIN    = JOIN_LOOKAHEAD
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NG = WIDTH / GROUP_W;

    logic [NG:0]   grp_cin;
    logic [NG-1:0] grp_cout;
    logic [NG-1:0] grp_p;
    logic [NG-1:0] grp_g;

    assign grp_cin[0] = carry_in;

    for (genvar k = 0; k < NG; k++) begin : g_grp
        cla_group #(.GW(GROUP_W)) u_grp (
            .a     (opa[k*GROUP_W +: GROUP_W]),
            .b     (opb[k*GROUP_W +: GROUP_W]),
            .cin   (grp_cin[k]),
            .sum   (sum_out[k*GROUP_W +: GROUP_W]),
            .cout  (grp_cout[k]),
            .gprop (grp_p[k]),
            .ggen  (grp_g[k])
        );
    end

    if (JOIN == JOIN_RIPPLE) begin : g_ripple
        // R5
        for (genvar k = 0; k < NG; k++) begin : g_link
            assign grp_cin[k+1] = grp_cout[k];
        end
    end else begin : g_look
        logic top_p;
        logic top_g;
        // R6
        cla_la_net #(.N(NG)) u_top (
            .p        (grp_p),
            .g        (grp_g),
            .c0       (carry_in),
            .carries  (grp_cin[NG:1]),
            .prop_all (top_p),
            .gen_all  (top_g)
        );
        always_comb begin
            // R6
            top_carry_chk: assert (carry_out == (top_g | (top_p & carry_in)))
                else $error("second-level carry-out mismatch");
        end
    end

    assign carry_out = grp_cin[NG];

    for (genvar k = 0; k < NG; k++) begin : g_link_chk
        always_comb begin
            // R5 R6
            link_chk: assert (grp_cin[k+1] == grp_cout[k])
                else $error("group %0d carry-in differs from predecessor carry-out", k + 1);
            // R4
            grp_term_chk: assert (grp_cout[k] == (grp_g[k] | (grp_p[k] & grp_cin[k])))
                else $error("group %0d P/G inconsistent", k);
        end
    end

    always_comb begin
        // R7
        total_sum_chk: assert ({carry_out, sum_out} ==
                               ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in}))
            else $error("adder result wrong");
    end

endmodule

// File: tb/cla_adder16_test.sv
`timescale 1ns/1ps
module cla_adder16_test;
    import cla_pkg::*;

    localparam int W = 16;

    typedef struct {
        logic [W:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s_la, s_rp;
    logic         co_la, co_rp;

    cla_adder16 #(.JOIN(JOIN_LOOKAHEAD)) uut (
        .opa(a), .opb(b), .carry_in(ci), .sum_out(s_la), .carry_out(co_la)
    );
    cla_adder16 #(.JOIN(JOIN_RIPPLE)) uut_rip (
        .opa(a), .opb(b), .carry_in(ci), .sum_out(s_rp), .carry_out(co_rp)
    );

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic push(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic c, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a  = x;
        b  = y;
        ci = c;
        it.exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares both variants, half a cycle after the drive
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if ({co_la, s_la} !== it.exp) begin
                n_bad++;
                $display("FAIL %s lookahead: got %h expected %h", it.tag, {co_la, s_la}, it.exp);
            end
            n_cmp++;
            if ({co_rp, s_rp} !== it.exp) begin
                n_bad++;
                $display("FAIL %s ripple: got %h expected %h", it.tag, {co_rp, s_rp}, it.exp);
            end
            // R11: the two variants agree
            n_cmp++;
            if ({co_la, s_la} !== {co_rp, s_rp}) begin
                n_bad++;
                $display("FAIL R11 variants differ: got %h expected %h", {co_rp, s_rp}, {co_la, s_la});
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R10 reset state with zero inputs, then zero plus carry
        push(16'h0000, 16'h0000, 1'b0, "R10 zero");
        push(16'h0000, 16'h0000, 1'b1, "R10 zero+cin");
        // R8
        push(16'hFFFF, 16'hFFFF, 1'b1, "R8 ones+cin");
        push(16'hFFFF, 16'hFFFF, 1'b0, "R8 ones");
        // R9 full propagate chain through every group
        push(16'hAAAA, 16'h5555, 1'b0, "R9 alt");
        push(16'hAAAA, 16'h5555, 1'b1, "R9 alt+cin");
        push(16'h5555, 16'h5555, 1'b1, "R9 alt same");
        push(16'hFFFF, 16'h0000, 1'b1, "R6 long chain");
        // R3 R4 R5: generate in one group carried across boundaries
        push(16'h000F, 16'h0001, 1'b0, "R5 group0 gen");
        push(16'h0F0F, 16'h00F1, 1'b0, "R4 group1 prop");
        push(16'h8000, 16'h8000, 1'b0, "R7 top carry");
        push(16'h0FFF, 16'h0001, 1'b0, "R3 inner carries");
        // R1 R2 R7: random vectors
        for (int i = 0; i < 2000; i++) begin
            push(16'($urandom), 16'($urandom), 1'($urandom), "R7 random");
        end
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule